// File: doc/BRIEF.md
# UART Channel Diagnostic Loopback Router

The router sits between one UART channel's receiver and transmitter, the serial line pins, and the CPU-side data and status paths. A 2-bit mode input picks one of four channel modes: normal (00), automatic echo (01), local loopback (10) and remote loopback (11). According to the mode, the block steers the serial data and the baud-rate enables between the two directions. It also cuts or passes the CPU's transmit link and the transmitter's ready and empty flags, and it passes or suppresses received data and receive error status.

In the two echo modes, a one-bit echo register samples the line on every receive baud enable and drives TxD. Parity, stop bits and a held-low break therefore go out exactly as they came in, one sample later, and nothing is regenerated. A mode change takes effect in the same cycle, even in the middle of a character, with one exception. If the receiver has just sampled a stop bit in an echo mode while the transmitter is enabled, leaving echo keeps the transmit side echoing until that stop bit has been fully re-sent.

Top module: `uart_diag_router`

## Requirements
- R1: In mode 00, rx_ser_o follows rxd_i, rx_baud_o follows rx_clk_en_i, txd_o follows tx_ser_i and tx_baud_o follows tx_clk_en_i. All CPU data and status pass through unchanged.
- R2: An echo register resets to 1 and loads rxd_i on every cycle in which rx_clk_en_i is 1. In modes 01 and 11, txd_o shows this register from the next cycle until the next load, so a low level that persists across samples (a break) is echoed low.
- R3: In mode 01, received data, valid and error status reach the CPU unchanged. tx_valid_o, cpu_tx_rdy_o and cpu_tx_emt_o are forced to 0, and tx_baud_o follows rx_clk_en_i.
- R4: In mode 10, rx_ser_o follows tx_ser_i, rx_baud_o follows tx_clk_en_i and txd_o is held at 1. rxd_i has no effect on rx_ser_o or txd_o.
- R5: In mode 11, txd_o carries the echo register, and cpu_rx_valid_o, cpu_rx_data_o and cpu_rx_err_o are all 0. The transmit link and flags are cut as in R3.
- R6: A change of mode_i changes all outputs in the same cycle, including in the middle of a character, except as given in R7.
- R7: When rx_stop_i pulses while mode_i is 01 or 11 and tx_en_i is 1, the transmit side stays in that echo mode until the end of the first cycle after the pulse in which rx_clk_en_i is 1, even if mode_i moves to 00 or 10. The transmit side covers txd_o, tx_baud_o, tx_valid_o and the transmit flags. The receive side follows mode_i at once.
- R8: When tx_en_i is 0 at the rx_stop_i pulse, no hold is taken and leaving echo is immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Channel mode: 00 normal, 01 auto echo, 10 local loop, 11 remote loop |
| tx_en_i | input | 1 | Transmitter enabled |
| rxd_i | input | 1 | Serial input pin |
| txd_o | output | 1 | Serial output pin |
| rx_clk_en_i | input | 1 | Receive baud sample enable |
| tx_clk_en_i | input | 1 | Transmit baud enable |
| rx_ser_o | output | 1 | Serial data to receiver |
| rx_baud_o | output | 1 | Baud enable to receiver |
| rx_stop_i | input | 1 | One-cycle pulse at receiver stop-bit sample |
| rx_data_i | input | DATA_W | Receiver character |
| rx_valid_i | input | 1 | Receiver character valid |
| rx_err_i | input | ERR_W | Receiver error flags |
| cpu_rx_data_o | output | DATA_W | Character to CPU |
| cpu_rx_valid_o | output | 1 | Character valid to CPU |
| cpu_rx_err_o | output | ERR_W | Error flags to CPU |
| tx_ser_i | input | 1 | Transmitter serial output |
| tx_baud_o | output | 1 | Baud enable to transmitter |
| cpu_tx_data_i | input | DATA_W | CPU character to send |
| cpu_tx_valid_i | input | 1 | CPU character valid |
| tx_data_o | output | DATA_W | Character to transmitter |
| tx_valid_o | output | 1 | Character valid to transmitter |
| tx_rdy_i | input | 1 | Transmitter ready flag |
| tx_emt_i | input | 1 | Transmitter empty flag |
| cpu_tx_rdy_o | output | 1 | Ready flag to CPU |
| cpu_tx_emt_o | output | 1 | Empty flag to CPU |

## Verification
The bench targets the exit from an echo mode right after a stop-bit pulse. A design without the hold would drop the stop bit from TxD and hand the transmitter to the CPU too early. A design that holds too long, or that also holds with the transmitter disabled, would keep TxD on the echo path after the line is released. The bench checks that the receive side switches at once during the hold, which a design holding the whole channel would miss. It also sends a sustained low to confirm that a break is echoed rather than regenerated. It drives rxd_i against tx_ser_i in local loop to catch a design that leaks the pin into the receiver or drives TxD from the transmitter.

// File: rtl/uart_diag_pkg.sv
package uart_diag_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_ECHO   = 2'b01,
    MODE_LOCAL  = 2'b10,
    MODE_REMOTE = 2'b11
  } chan_mode_e;

  function automatic logic is_echo(input logic [1:0] m);
    return (m == MODE_ECHO) || (m == MODE_REMOTE);
  endfunction
endpackage

// File: rtl/udr_echo_path.sv
module udr_echo_path
  import uart_diag_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       tx_en_i,
  input  logic       rxd_i,
  input  logic       rx_clk_en_i,
  input  logic       rx_stop_i,
  output logic       echo_bit_o,
  output logic [1:0] tx_mode_o
);
  logic       echo_q;
  logic       hold_q;
  logic [1:0] hold_mode_q;
  logic       echo_now;

  assign echo_now = is_echo(mode_i);

  // reclock the line on each receive sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          echo_q <= 1'b1;
    else if (rx_clk_en_i) echo_q <= rxd_i;
  end

  // pending exit: stop bit is being re-sent until the next sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= 1'b0;
      hold_mode_q <= MODE_ECHO;
    end else if (rx_stop_i && echo_now && tx_en_i) begin
      hold_q      <= 1'b1;
      hold_mode_q <= mode_i;
    end else if (rx_clk_en_i) begin
      hold_q      <= 1'b0;
    end
  end

  assign echo_bit_o = echo_q;
  assign tx_mode_o  = (hold_q && !echo_now) ? hold_mode_q : mode_i;

  AST_ECHO_RECLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clk_en_i |=> (echo_bit_o == $past(rxd_i))); // R2
  AST_ECHO_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_clk_en_i |=> $stable(echo_bit_o)); // R2
  AST_HOLD_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_stop_i && echo_now && tx_en_i) |=> hold_q); // R7
  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_clk_en_i && !rx_stop_i) |=> !hold_q); // R7
  AST_NO_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && !tx_en_i) |=> !hold_q); // R8
endmodule

// File: rtl/udr_rx_gate.sv
module udr_rx_gate
  import uart_diag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4
) (
  input  logic [1:0]        mode_i,
  input  logic              rxd_i,
  input  logic              tx_ser_i,
  input  logic              rx_clk_en_i,
  input  logic              tx_clk_en_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  output logic              rx_ser_o,
  output logic              rx_baud_o,
  output logic [DATA_W-1:0] cpu_rx_data_o,
  output logic              cpu_rx_valid_o,
  output logic [ERR_W-1:0]  cpu_rx_err_o
);
  logic local_loop;
  logic remote_loop;

  assign local_loop  = (mode_i == MODE_LOCAL);
  assign remote_loop = (mode_i == MODE_REMOTE);

  // internal loop taps the transmitter before the pin override
  assign rx_ser_o       = local_loop ? tx_ser_i : rxd_i;
  assign rx_baud_o      = local_loop ? tx_clk_en_i : rx_clk_en_i;
  assign cpu_rx_data_o  = remote_loop ? '0 : rx_data_i;
  assign cpu_rx_valid_o = remote_loop ? 1'b0 : rx_valid_i;
  assign cpu_rx_err_o   = remote_loop ? '0 : rx_err_i;
endmodule

// File: rtl/udr_tx_gate.sv
module udr_tx_gate
  import uart_diag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        tx_mode_i,
  input  logic              echo_bit_i,
  input  logic              tx_ser_i,
  input  logic              rx_clk_en_i,
  input  logic              tx_clk_en_i,
  input  logic [DATA_W-1:0] cpu_tx_data_i,
  input  logic              cpu_tx_valid_i,
  input  logic              tx_rdy_i,
  input  logic              tx_emt_i,
  output logic              txd_o,
  output logic              tx_baud_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              cpu_tx_rdy_o,
  output logic              cpu_tx_emt_o
);
  logic echo_tx;

  assign echo_tx = is_echo(tx_mode_i);

  always_comb begin
    unique case (tx_mode_i)
      MODE_NORMAL: txd_o = tx_ser_i;
      MODE_LOCAL:  txd_o = 1'b1;
      default:     txd_o = echo_bit_i;
    endcase
  end

  assign tx_baud_o    = echo_tx ? rx_clk_en_i : tx_clk_en_i;
  assign tx_data_o    = cpu_tx_data_i;
  assign tx_valid_o   = echo_tx ? 1'b0 : cpu_tx_valid_i;
  assign cpu_tx_rdy_o = echo_tx ? 1'b0 : tx_rdy_i;
  assign cpu_tx_emt_o = echo_tx ? 1'b0 : tx_emt_i;
endmodule

// File: rtl/uart_diag_router.sv
module uart_diag_router
  import uart_diag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              tx_en_i,
  input  logic              rxd_i,
  output logic              txd_o,
  input  logic              rx_clk_en_i,
  input  logic              tx_clk_en_i,
  output logic              rx_ser_o,
  output logic              rx_baud_o,
  input  logic              rx_stop_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  output logic [DATA_W-1:0] cpu_rx_data_o,
  output logic              cpu_rx_valid_o,
  output logic [ERR_W-1:0]  cpu_rx_err_o,
  input  logic              tx_ser_i,
  output logic              tx_baud_o,
  input  logic [DATA_W-1:0] cpu_tx_data_i,
  input  logic              cpu_tx_valid_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_rdy_i,
  input  logic              tx_emt_i,
  output logic              cpu_tx_rdy_o,
  output logic              cpu_tx_emt_o
);
  logic       echo_bit;
  logic [1:0] tx_mode;

  udr_echo_path u_echo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .tx_en_i     (tx_en_i),
    .rxd_i       (rxd_i),
    .rx_clk_en_i (rx_clk_en_i),
    .rx_stop_i   (rx_stop_i),
    .echo_bit_o  (echo_bit),
    .tx_mode_o   (tx_mode)
  );

  udr_rx_gate #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_rx (
    .mode_i         (mode_i),
    .rxd_i          (rxd_i),
    .tx_ser_i       (tx_ser_i),
    .rx_clk_en_i    (rx_clk_en_i),
    .tx_clk_en_i    (tx_clk_en_i),
    .rx_data_i      (rx_data_i),
    .rx_valid_i     (rx_valid_i),
    .rx_err_i       (rx_err_i),
    .rx_ser_o       (rx_ser_o),
    .rx_baud_o      (rx_baud_o),
    .cpu_rx_data_o  (cpu_rx_data_o),
    .cpu_rx_valid_o (cpu_rx_valid_o),
    .cpu_rx_err_o   (cpu_rx_err_o)
  );

  udr_tx_gate #(.DATA_W(DATA_W)) u_tx (
    .tx_mode_i      (tx_mode),
    .echo_bit_i     (echo_bit),
    .tx_ser_i       (tx_ser_i),
    .rx_clk_en_i    (rx_clk_en_i),
    .tx_clk_en_i    (tx_clk_en_i),
    .cpu_tx_data_i  (cpu_tx_data_i),
    .cpu_tx_valid_i (cpu_tx_valid_i),
    .tx_rdy_i       (tx_rdy_i),
    .tx_emt_i       (tx_emt_i),
    .txd_o          (txd_o),
    .tx_baud_o      (tx_baud_o),
    .tx_data_o      (tx_data_o),
    .tx_valid_o     (tx_valid_o),
    .cpu_tx_rdy_o   (cpu_tx_rdy_o),
    .cpu_tx_emt_o   (cpu_tx_emt_o)
  );

  AST_REMOTE_RX_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_REMOTE) |-> (!cpu_rx_valid_o && cpu_rx_err_o == '0)); // R5
  AST_LOCAL_RX_FROM_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOCAL) |-> (rx_ser_o == tx_ser_i && rx_baud_o == tx_clk_en_i)); // R4
  AST_ECHO_TX_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_echo(mode_i) |-> (!tx_valid_o && !cpu_tx_rdy_o && !cpu_tx_emt_o)); // R3
  AST_ECHO_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_echo(mode_i) && !rx_clk_en_i) |=> (!is_echo(mode_i) || $stable(txd_o))); // R2
endmodule

// File: tb/tb_uart_diag_router.sv
`timescale 1ns/1ps
module tb_uart_diag_router;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic tx_en = 1'b1, rxd = 1'b1, rx_ce = 1'b0, tx_ce = 1'b0, rx_stop = 1'b0;
  logic [DATA_W-1:0] rx_data = '0, cpu_tx_data = '0;
  logic rx_valid = 1'b0, cpu_tx_valid = 1'b0, tx_ser = 1'b1, tx_rdy = 1'b0, tx_emt = 1'b0;
  logic [ERR_W-1:0] rx_err = '0;
  logic txd, rx_ser, rx_baud, tx_baud, cpu_rx_valid, tx_valid, cpu_tx_rdy, cpu_tx_emt;
  logic [DATA_W-1:0] cpu_rx_data, tx_data;
  logic [ERR_W-1:0] cpu_rx_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_diag_router #(.DATA_W(DATA_W), .ERR_W(ERR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tx_en_i(tx_en),
    .rxd_i(rxd), .txd_o(txd), .rx_clk_en_i(rx_ce), .tx_clk_en_i(tx_ce),
    .rx_ser_o(rx_ser), .rx_baud_o(rx_baud), .rx_stop_i(rx_stop),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_err_i(rx_err),
    .cpu_rx_data_o(cpu_rx_data), .cpu_rx_valid_o(cpu_rx_valid), .cpu_rx_err_o(cpu_rx_err),
    .tx_ser_i(tx_ser), .tx_baud_o(tx_baud), .cpu_tx_data_i(cpu_tx_data),
    .cpu_tx_valid_i(cpu_tx_valid), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_rdy_i(tx_rdy), .tx_emt_i(tx_emt), .cpu_tx_rdy_o(cpu_tx_rdy), .cpu_tx_emt_o(cpu_tx_emt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns later (combinational paths settled)
  task automatic step();
    @(negedge clk); #1;
  endtask

  // one receive sample of bit b; txd shows it after the loading edge
  task automatic sample_bit(input logic b, input logic stop);
    @(negedge clk); rxd = b; rx_ce = 1'b1; rx_stop = stop;
    @(negedge clk); rx_ce = 1'b0; rx_stop = 1'b0; #1;
  endtask

  task automatic t_reset();
    mode = 2'b01; #1;
    check("R2 reset echo idle", txd, 1);
    mode = 2'b00; #1;
  endtask

  task automatic t_normal();
    @(negedge clk); mode = 2'b00; rxd = 0; tx_ser = 0; rx_ce = 1; tx_ce = 0;
    rx_valid = 1; rx_data = 8'hA5; rx_err = 4'h3;
    cpu_tx_valid = 1; cpu_tx_data = 8'h3C; tx_rdy = 1; tx_emt = 1; #1;
    check("R1 rx_ser", rx_ser, 0);
    check("R1 rx_baud", rx_baud, 1);
    check("R1 txd", txd, 0);
    check("R1 tx_baud", tx_baud, 0);
    check("R1 cpu rx data/err/valid", {cpu_rx_valid, cpu_rx_err, cpu_rx_data}, {1'b1, 4'h3, 8'hA5});
    check("R1 tx link/flags", {tx_valid, cpu_tx_rdy, cpu_tx_emt, tx_data}, {3'b111, 8'h3C});
    @(negedge clk); rx_ce = 0; tx_ce = 1; rxd = 1; tx_ser = 1; #1;
    check("R1 txd high", txd, 1);
    check("R1 tx_baud", tx_baud, 1);
    tx_ce = 0;
  endtask

  task automatic t_auto_echo();
    @(negedge clk); mode = 2'b01; tx_ser = 1; #1;
    check("R3 cpu rx passes", {cpu_rx_valid, cpu_rx_err, cpu_rx_data}, {1'b1, 4'h3, 8'hA5});
    check("R3 tx link cut", {tx_valid, cpu_tx_rdy, cpu_tx_emt}, 0);
    sample_bit(0, 0);
    check("R2 echo start bit", txd, 0);
    step();
    check("R2 echo holds between samples", txd, 0);
    sample_bit(1, 0);
    check("R2 echo data 1", txd, 1);
    @(negedge clk); rx_ce = 1; #1;
    check("R3 tx_baud follows rx", tx_baud, 1);
    @(negedge clk); rx_ce = 0;
  endtask

  task automatic t_break();
    @(negedge clk); mode = 2'b01;
    for (int i = 0; i < 12; i++) sample_bit(0, 0);
    check("R2 break echoed low", txd, 0);
    sample_bit(1, 0);
    check("R2 break release", txd, 1);
  endtask

  task automatic t_local();
    @(negedge clk); mode = 2'b10; rxd = 0; tx_ser = 1; tx_ce = 1; rx_ce = 0; #1;
    check("R4 rx_ser from tx", rx_ser, 1);
    check("R4 rx_baud from tx", rx_baud, 1);
    check("R4 txd held high", txd, 1);
    tx_ser = 0; rxd = 1; #1;
    check("R4 rx_ser ignores rxd", rx_ser, 0);
    check("R4 txd still high", txd, 1);
    tx_ce = 0;
  endtask

  task automatic t_remote();
    @(negedge clk); mode = 2'b11; tx_ser = 1; #1;
    check("R5 cpu rx silent", {cpu_rx_valid, cpu_rx_err, cpu_rx_data}, 0);
    check("R5 tx link cut", {tx_valid, cpu_tx_rdy, cpu_tx_emt}, 0);
    sample_bit(0, 0);
    check("R5 echo on txd", txd, 0);
    sample_bit(1, 0);
  endtask

  task automatic t_immediate();
    @(negedge clk); mode = 2'b01;
    sample_bit(0, 0);          // mid-character, echo low
    tx_ser = 1; mode = 2'b00; #1;
    check("R6 immediate leave echo", txd, 1);
    check("R6 tx link restored", tx_valid, 1);
    mode = 2'b11; #1;
    check("R6 immediate enter remote", cpu_rx_valid, 0);
    sample_bit(1, 0);
  endtask

  task automatic t_exit_hold();
    @(negedge clk); mode = 2'b11; tx_en = 1; tx_ser = 0;
    sample_bit(1, 1);          // stop bit sampled
    mode = 2'b10; tx_ce = 1; #1;
    check("R7 held tx baud echo", tx_baud, 0);
    check("R7 held tx link cut", tx_valid, 0);
    check("R7 rx side switched", rx_ser, 0);
    check("R7 rx baud switched", rx_baud, 1);
    step(); step();
    check("R7 still held", tx_valid, 0);
    mode = 2'b00; #1;
    check("R7 held txd echo", txd, 1);
    @(negedge clk); rx_ce = 1; rxd = 0; #1;
    check("R7 held through sample", txd, 1);
    @(negedge clk); rx_ce = 0; #1;
    check("R7 released txd", txd, 0);
    check("R7 released link", tx_valid, 1);
    tx_ce = 0; rxd = 1;
  endtask

  task automatic t_exit_no_hold();
    @(negedge clk); mode = 2'b01; tx_en = 0; tx_ser = 0;
    sample_bit(1, 1);
    mode = 2'b00; #1;
    check("R8 no hold when tx disabled", txd, 0);
    check("R8 link restored", tx_valid, 1);
    tx_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_auto_echo();
    t_break();
    t_local();
    t_remote();
    t_immediate();
    t_exit_hold();
    t_exit_no_hold();
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule